// File: doc/BRIEF.md
# Per-Bit Edge Event Interrupt Latch

This block watches 24 input channels, grouped as three 8-bit ports, for level transitions. Every channel has its own polarity bit, which picks a rising or a falling edge, and its own enable bit. An enabled channel that sees an edge of its chosen polarity sets a sticky pending bit. Any pending bit drives a single combined interrupt request, which stays high until software has acknowledged every pending event.

Software reaches the polarity, enable and pending (interrupt-ID) registers through a small register-access port. Reads return data one cycle after the request. A summary register shows which ports hold pending events, so an interrupt handler can go straight to the right ID register. Software can acknowledge all events of a port at once by writing anything to that port's ID register. It can acknowledge a single event by clearing that channel's enable bit and then setting it again. Pin levels pass through a synchronizer before edges are detected, so a pulse held for one sampled clock cycle is still caught.

Top module: `evs_event_latch`

## Requirements
- R1: The address is split into a group field, addr[3:2], and a port index, addr[1:0]. Group 0 holds polarity, group 1 enable, group 2 pending ID, and group 3 index 0 the summary. Port indexes 0 to 2 map to channels 0-7, 8-15 and 16-23. Reads of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R2: A polarity bit of 1 selects a rising edge of the physical pin level, and a 0 selects a falling edge. An edge of the other direction sets nothing.
- R3: A pending bit can only be set while its enable bit is 1. An edge that arrives while the channel is disabled is discarded and does not appear when the channel is enabled later.
- R4: A pending bit is sticky. A pin pulse that lasts a single clock cycle sets it, and it stays set after the pin returns to its old level.
- R5: A write of any data value to a port's ID register clears every pending bit of that port in the next cycle. Pending bits of the other ports are untouched.
- R6: Writing an enable bit to 0 clears that channel's pending bit in the same write. Other pending bits of the port stay set, and enabling the channel again does not bring the bit back.
- R7: Summary bit n reads 1 exactly when ID register n has any bit set. The upper summary bits read 0.
- R8: If an edge would set a pending bit in the same cycle as a write to that port's ID register, the clear wins and the bit stays 0.
- R9: The interrupt request is the OR of all 24 pending bits. It stays high until all of them are cleared.
- R10: The interrupt request and the pending bit rise on the third rising clock edge after a pin change that falls between two edges. After two edges the request is still low.
- R11: After reset, all polarity, enable and pending bits are 0, the interrupt request is low and the read-valid output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Asynchronous channel input levels |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 4 | Register address: group in [3:2], port index in [1:0] |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | High for one cycle, one cycle after acc_rd |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after the timing overlaps. It lands an ID-register write on the exact cycle in which an edge would latch. A design that let the set win would leave a stale event pending. It sends a one-cycle pin pulse, which a design sampling raw levels too late would miss. It sends an edge while the channel is disabled and then enables the channel. A design that delayed the enable check would report a ghost event. It clears a single bit through its enable and checks both that the neighbouring bits survive and that the bit does not come back when the channel is enabled again. It writes to one port's ID register to show that the other ports keep their events. It samples the request one cycle before and at the cycle it must rise, which catches a synchronizer that is one stage too short or too long.

// File: rtl/evs_pkg.sv
package evs_pkg;

  // Address group field, addr[3:2]
  typedef enum logic [1:0] {
    GRP_POL = 2'd0,
    GRP_ENA = 2'd1,
    GRP_ID  = 2'd2,
    GRP_SUM = 2'd3
  } evs_grp_e;

  localparam int unsigned IDX_W = 2;
  localparam int unsigned ADDR_W = 2 + IDX_W;

endpackage

// File: rtl/evs_sync.sv
module evs_sync #(
  parameter int unsigned W      = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] lvl_prev_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;
  logic [W-1:0]             prev_q;

  // Next-state: shift the raw levels through the chain
  always_comb begin
    chain_d[0] = pin_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o      = chain_q[STAGES-1];
  assign lvl_prev_o = prev_q;

endmodule

// File: rtl/evs_port.sv
module evs_port #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] lvl_i,
  input  logic [PW-1:0] lvl_prev_i,
  input  logic          pol_we_i,
  input  logic          ena_we_i,
  input  logic          id_we_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] pol_o,
  output logic [PW-1:0] ena_o,
  output logic [PW-1:0] pend_o
);

  logic [PW-1:0] pol_q;
  logic [PW-1:0] ena_q;
  logic [PW-1:0] ena_d;
  logic [PW-1:0] pend_q;
  logic [PW-1:0] pend_d;
  logic [PW-1:0] hit;

  // Per-channel edge match against the selected polarity
  for (genvar b = 0; b < PW; b++) begin : g_bit
    logic rise;
    logic fall;
    assign rise   = lvl_i[b] & ~lvl_prev_i[b];
    assign fall   = ~lvl_i[b] & lvl_prev_i[b];
    assign hit[b] = pol_q[b] ? rise : fall;
  end

  // Next-state for enables and pending bits
  always_comb begin
    ena_d  = ena_we_i ? wdata_i : ena_q;
    pend_d = (pend_q | (hit & ena_q)) & ena_d;
    if (id_we_i) begin
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (pol_we_i) begin
      pol_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_we_i) begin
      ena_q <= ena_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pol_o  = pol_q;
  assign ena_o  = ena_q;
  assign pend_o = pend_q;

  AST_ID_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    id_we_i |=> (pend_q == '0)); // R5

  AST_NEW_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & ~$past(pend_q) & ~$past(ena_q)) == '0)); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_we_i && !ena_we_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4

  AST_ENA_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ena_we_i |=> ((pend_q & ~ena_q) == '0)); // R6

endmodule

// File: rtl/evs_readmux.sv
module evs_readmux
  import evs_pkg::*;
#(
  parameter int unsigned NPORT = 3,
  parameter int unsigned PW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_i,
  input  evs_grp_e                    grp_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [NPORT-1:0][PW-1:0]    pol_i,
  input  logic [NPORT-1:0][PW-1:0]    ena_i,
  input  logic [NPORT-1:0][PW-1:0]    pend_i,
  output logic [PW-1:0]               rdata_o,
  output logic                        rvalid_o
);

  logic [NPORT-1:0] summary;
  logic [PW-1:0]    rdata_d;
  logic [PW-1:0]    rdata_q;
  logic             rvalid_q;
  logic             idx_ok;

  for (genvar p = 0; p < NPORT; p++) begin : g_sum
    assign summary[p] = |pend_i[p];
  end

  assign idx_ok = (int'(idx_i) < NPORT);

  always_comb begin
    rdata_d = '0;
    unique case (grp_i)
      GRP_POL: if (idx_ok) rdata_d = pol_i[idx_i];
      GRP_ENA: if (idx_ok) rdata_d = ena_i[idx_i];
      GRP_ID:  if (idx_ok) rdata_d = pend_i[idx_i];
      GRP_SUM: if (idx_i == '0) rdata_d = PW'(summary);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_SUMMARY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && grp_i == GRP_SUM && idx_i == '0 && pend_i == '0) |=> (rdata_q == '0)); // R7

endmodule

// File: rtl/evs_event_latch.sv
module evs_event_latch
  import evs_pkg::*;
#(
  parameter int unsigned NPORT       = 3,
  parameter int unsigned PW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT*PW-1:0]   pin_i,
  input  logic                  acc_wr,
  input  logic                  acc_rd,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [PW-1:0]         acc_wdata,
  output logic [PW-1:0]         acc_rdata,
  output logic                  acc_rvalid,
  output logic                  irq_o
);

  localparam int unsigned NCH = NPORT * PW;

  evs_grp_e                 grp;
  logic [IDX_W-1:0]         idx;
  logic [NCH-1:0]           lvl;
  logic [NCH-1:0]           lvl_prev;
  logic [NPORT-1:0][PW-1:0] pol_all;
  logic [NPORT-1:0][PW-1:0] ena_all;
  logic [NPORT-1:0][PW-1:0] pend_all;

  assign grp = evs_grp_e'(acc_addr[ADDR_W-1:IDX_W]);
  assign idx = acc_addr[IDX_W-1:0];

  evs_sync #(
    .W      (NCH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .lvl_o      (lvl),
    .lvl_prev_o (lvl_prev)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = acc_wr && (int'(idx) == p);

    evs_port #(
      .PW (PW)
    ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl[p*PW +: PW]),
      .lvl_prev_i (lvl_prev[p*PW +: PW]),
      .pol_we_i   (sel && grp == GRP_POL),
      .ena_we_i   (sel && grp == GRP_ENA),
      .id_we_i    (sel && grp == GRP_ID),
      .wdata_i    (acc_wdata),
      .pol_o      (pol_all[p]),
      .ena_o      (ena_all[p]),
      .pend_o     (pend_all[p])
    );
  end

  evs_readmux #(
    .NPORT (NPORT),
    .PW    (PW)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (acc_rd),
    .grp_i    (grp),
    .idx_i    (idx),
    .pol_i    (pol_all),
    .ena_i    (ena_all),
    .pend_i   (pend_all),
    .rdata_o  (acc_rdata),
    .rvalid_o (acc_rvalid)
  );

  assign irq_o = |pend_all;

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !acc_wr) |=> irq_o); // R9

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> acc_rvalid); // R1

endmodule

// File: tb/sim_evs_event_latch.sv
module sim_evs_event_latch;

  logic        clk;
  logic        rst_n;
  logic [23:0] pins;
  logic        acc_wr;
  logic        acc_rd;
  logic [3:0]  acc_addr;
  logic [7:0]  acc_wdata;
  logic [7:0]  acc_rdata;
  logic        acc_rvalid;
  logic        irq_o;

  int checks;
  int failures;
  bit done;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] addr_q[$];

  evs_event_latch u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pins),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .irq_o      (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [3:0] POL0 = 4'h0, POL1 = 4'h1, POL2 = 4'h2;
  localparam logic [3:0] ENA0 = 4'h4, ENA1 = 4'h5, ENA2 = 4'h6;
  localparam logic [3:0] ID0  = 4'h8, ID1  = 4'h9, ID2  = 4'hA;
  localparam logic [3:0] SUM  = 4'hC;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the expected read results as the design returns them
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data: actual %02h expected none", acc_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        logic [3:0] a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = addr_q.pop_front();
        if (acc_rdata !== e) begin
          failures++;
          $display("FAIL %s addr %h: actual %02h expected %02h", t, a, acc_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  // Driver: pushes the expected value and issues the read
  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr_q.push_back(a);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pins[n] = v;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      failures++;
      $display("FAIL %s irq: actual %b expected %b", t, irq_o, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; pins = '0;
    acc_wr = 1'b0; acc_rd = 1'b0; acc_addr = '0; acc_wdata = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // R11 reset state
    check_irq(1'b0, "R11");
    checks++;
    if (acc_rvalid !== 1'b0) begin
      failures++;
      $display("FAIL R11 rvalid: actual %b expected 0", acc_rvalid);
    end
    rd(POL0, 8'h00, "R11"); rd(ENA1, 8'h00, "R11");
    rd(ID2, 8'h00, "R11");  rd(SUM, 8'h00, "R11");

    // R2 rising edge on channel 0
    wr(POL0, 8'hFF); wr(ENA0, 8'h01);
    set_pin(0, 1'b1); wait_cyc(4);
    rd(ID0, 8'h01, "R2"); rd(SUM, 8'h01, "R7");
    check_irq(1'b1, "R9");

    // R5 ID write with zero data still clears
    wr(ID0, 8'h00);
    rd(ID0, 8'h00, "R5");
    check_irq(1'b0, "R9");

    // R2 falling polarity on channel 12 (port 1 bit 4)
    wr(ENA1, 8'h10);
    set_pin(12, 1'b1); wait_cyc(4);
    rd(ID1, 8'h00, "R2");
    set_pin(12, 1'b0); wait_cyc(4);
    rd(ID1, 8'h10, "R2"); rd(SUM, 8'h02, "R7");

    // R3 edge while disabled is discarded
    wr(POL2, 8'hFF);
    set_pin(16, 1'b1); wait_cyc(5);
    rd(ID2, 8'h00, "R3");
    wr(ENA2, 8'h01); wait_cyc(4);
    rd(ID2, 8'h00, "R3");
    set_pin(16, 1'b0); wait_cyc(4);
    set_pin(16, 1'b1); wait_cyc(4);
    rd(ID2, 8'h01, "R3"); rd(SUM, 8'h06, "R7");

    // R6 single-bit clear through enable
    wr(ENA1, 8'h00);
    rd(ID1, 8'h00, "R6"); rd(ID2, 8'h01, "R6");
    wr(ENA2, 8'h03);
    set_pin(17, 1'b1); wait_cyc(4);
    rd(ID2, 8'h03, "R6");
    wr(ENA2, 8'h02);
    rd(ID2, 8'h02, "R6");
    wr(ENA2, 8'h03);
    rd(ID2, 8'h02, "R6"); rd(SUM, 8'h04, "R7");

    // R5 clear is per port
    set_pin(0, 1'b0); wait_cyc(4);
    set_pin(0, 1'b1); wait_cyc(4);
    rd(ID0, 8'h01, "R5");
    wr(ID2, 8'hFF);
    rd(ID2, 8'h00, "R5"); rd(ID0, 8'h01, "R5");
    wr(ID0, 8'h5A);
    rd(ID0, 8'h00, "R5");
    check_irq(1'b0, "R9");

    // R10 latency: request rises on the third edge
    wr(ENA0, 8'h21);
    set_pin(5, 1'b1);
    @(negedge clk); check_irq(1'b0, "R10");
    @(negedge clk); check_irq(1'b0, "R10");
    @(negedge clk); check_irq(1'b1, "R10");
    wr(ID0, 8'h00);

    // R4 single-cycle pulse is latched and sticky
    wr(ENA0, 8'h80);
    set_pin(7, 1'b1); set_pin(7, 1'b0);
    wait_cyc(4);
    rd(ID0, 8'h80, "R4");
    wait_cyc(6);
    rd(ID0, 8'h80, "R4");
    check_irq(1'b1, "R4");
    wr(ID0, 8'h00);

    // R8 clear write coincides with the latching edge
    wr(ENA0, 8'hC0);
    set_pin(6, 1'b1);
    @(negedge clk);
    wr(ID0, 8'h33);
    wait_cyc(4);
    rd(ID0, 8'h00, "R8");
    check_irq(1'b0, "R8");

    // R1 unmapped addresses
    rd(4'h3, 8'h00, "R1");
    wr(4'h3, 8'hFF);
    rd(POL0, 8'hFF, "R1");
    rd(4'hD, 8'h00, "R1");
    rd(4'hB, 8'h00, "R1");
    wr(4'h7, 8'hFF);
    rd(ENA0, 8'hC0, "R1");
    rd(POL1, 8'h00, "R1");

    wait_cyc(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 pending reads: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule